// File: doc/BRIEF.md
# Serial Firmware Page Loader

This block takes bytes from a UART receiver and uses them to rewrite a page-organised EEPROM. It first waits for a two-byte start marker. Payload bytes then go into a single reusable 64-byte page buffer, and each byte updates a running CRC-16 as it is accepted. When the buffer is full, its contents go out to the EEPROM as a burst of byte writes. A one-cycle commit strobe follows the burst. The loader then stops consuming input until the EEPROM drops its busy flag.

A two-byte end marker closes the payload. Any partial page left in the buffer is flushed. The two check bytes that follow are compared against the running CRC, and a one-cycle success or failure pulse reports the result. Pages reach the EEPROM before the checksum is known, so a failed transfer has already overwritten memory. In either case the loader goes back to hunting for a start marker. A 16-entry receive FIFO absorbs the bytes that keep arriving during a page burst and the EEPROM busy time. The payload must not contain the end-marker byte pair.

Top module: `fw_page_loader`

## Requirements
- R1: After reset, ee_we, ee_commit, load_ok and load_err are low and the loader is hunting for a start marker.
- R2: The start marker is byte 0xA5 immediately followed by byte 0x5A. While hunting, every other byte is discarded without any EEPROM write or result pulse, and a repeated 0xA5 before 0x5A still starts a transfer.
- R3: Payload bytes are written in arrival order to consecutive EEPROM addresses beginning at 0 for every new transfer. Each page burst starts at the previous page's start address plus the previous page's length.
- R4: After 64 payload bytes have filled the page buffer, the loader issues exactly 64 ee_we cycles and then a single one-cycle ee_commit in the cycle after the last write.
- R5: After ee_commit, no ee_we is issued and no input byte is consumed while ee_busy is high.
- R6: The receive FIFO holds up to 16 bytes that arrive while the loader is writing or waiting, so that no byte is lost.
- R7: The end marker is byte 0xC3 immediately followed by 0x3C. Neither marker byte is written. A non-empty partial page is flushed with its exact length, and an empty one causes no write.
- R8: The check value is CRC-16 with polynomial 0x1021, initial value 0x0000, processed MSB first, over the payload bytes only. It is received as the two bytes after the end marker, high byte first. A match gives a one-cycle load_ok, and a mismatch gives a one-cycle load_err. The two never occur together.
- R9: After either result the loader returns to hunting, and pages of a failed transfer stay written. The next transfer starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present on rx_data this cycle |
| rx_data | input | 8 | Received byte |
| ee_we | output | 1 | Byte write strobe towards the EEPROM page latch |
| ee_addr | output | ADDR_W (15) | EEPROM byte address for ee_we |
| ee_wdata | output | 8 | Byte to write |
| ee_commit | output | 1 | One-cycle pulse that starts the EEPROM page program |
| ee_busy | input | 1 | EEPROM is programming a page |
| load_ok | output | 1 | One-cycle pulse: check value matched |
| load_err | output | 1 | One-cycle pulse: check value mismatched |

## Verification
Two things regularly land in the same cycle. One is the arrival of a new UART byte into the FIFO. The other is the loader's own activity at that moment: popping a byte, running a page burst, or waiting on the EEPROM busy flag. The bench spaces bytes eight cycles apart and holds the modelled EEPROM busy for 48 cycles, so every page boundary overlaps a burst plus a busy window with continuing input, and the FIFO sees a push and a pop in the same cycle. Transfers are judged at the ports by the recorded burst start addresses and lengths, by a byte-for-byte comparison of the modelled EEPROM against the sent image, and by the result pulses.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

  typedef enum logic [2:0] {
    ST_HUNT, ST_DATA, ST_PGWR, ST_PGCMT, ST_PGWAIT, ST_CRCH, ST_CRCL
  } fpl_state_e;

  // One byte of CRC-16, polynomial 0x1021, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

endpackage

// File: rtl/fpl_rx_fifo.sv
module fpl_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [PTR_W:0] wr_p, rd_p;
  logic           full;

  assign level = LVL_W'(wr_p - rd_p);
  assign empty = (wr_p == rd_p);
  assign full  = (level == LVL_W'(DEPTH));
  assign dout  = mem[rd_p[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
    end else begin
      if (push && !full) begin
        mem[wr_p[PTR_W-1:0]] <= din;
        wr_p <= wr_p + 1'b1;
      end
      if (pop && !empty) rd_p <= rd_p + 1'b1;
    end
  end
endmodule

// File: rtl/fpl_page_buf.sv
module fpl_page_buf #(
  parameter int PAGE = 64
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(PAGE)-1:0] waddr,
  input  logic [7:0]              wdata,
  input  logic [$clog2(PAGE)-1:0] raddr,
  output logic [7:0]              rdata
);
  logic [7:0] cells [PAGE];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fw_page_loader.sv
module fw_page_loader
  import fpl_pkg::*;
#(
  parameter int          ADDR_W     = 15,
  parameter int          PAGE       = 64,
  parameter int          FIFO_DEPTH = 16,
  parameter logic [7:0]  SOF_A      = 8'hA5,
  parameter logic [7:0]  SOF_B      = 8'h5A,
  parameter logic [7:0]  EOF_A      = 8'hC3,
  parameter logic [7:0]  EOF_B      = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              ee_we,
  output logic [ADDR_W-1:0] ee_addr,
  output logic [7:0]        ee_wdata,
  output logic              ee_commit,
  input  logic              ee_busy,
  output logic              load_ok,
  output logic              load_err
);
  localparam int IDX_W = $clog2(PAGE);
  localparam int CNT_W = IDX_W + 1;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  fpl_state_e        state;
  logic              sof_seen, have_pend, end_seen;
  logic [7:0]        pend, rcv_hi, head;
  logic [CNT_W-1:0]  cnt, idx;
  logic [ADDR_W-1:0] base;
  logic [15:0]       crc;
  logic              fifo_empty;
  logic [LVL_W-1:0]  fifo_level;

  // Named internal events, observed by the checker.
  logic byte_take, start_evt, end_evt, store_evt, page_full, last_wr, crc_match;
  logic [CNT_W-1:0] page_fill;

  assign byte_take = !fifo_empty &&
                     (state == ST_HUNT || state == ST_DATA ||
                      state == ST_CRCH || state == ST_CRCL);
  assign start_evt = byte_take && state == ST_HUNT && sof_seen && head == SOF_B;
  assign end_evt   = byte_take && state == ST_DATA && have_pend &&
                     pend == EOF_A && head == EOF_B;
  assign store_evt = byte_take && state == ST_DATA && have_pend && !end_evt;
  assign page_full = store_evt && cnt == CNT_W'(PAGE - 1);
  assign last_wr   = state == ST_PGWR && idx == cnt - 1'b1;
  assign crc_match = ({rcv_hi, head} == crc);
  assign page_fill = cnt;

  fpl_rx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_valid),
    .din   (rx_data),
    .pop   (byte_take),
    .dout  (head),
    .empty (fifo_empty),
    .level (fifo_level)
  );

  fpl_page_buf #(.PAGE(PAGE)) u_buf (
    .clk   (clk),
    .we    (store_evt),
    .waddr (cnt[IDX_W-1:0]),
    .wdata (pend),
    .raddr (idx[IDX_W-1:0]),
    .rdata (ee_wdata)
  );

  assign ee_we     = (state == ST_PGWR);
  assign ee_commit = (state == ST_PGCMT);
  assign ee_addr   = base + ADDR_W'(idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      sof_seen  <= 1'b0;
      have_pend <= 1'b0;
      end_seen  <= 1'b0;
      pend      <= '0;
      rcv_hi    <= '0;
      cnt       <= '0;
      idx       <= '0;
      base      <= '0;
      crc       <= '0;
      load_ok   <= 1'b0;
      load_err  <= 1'b0;
    end else begin
      load_ok  <= 1'b0;
      load_err <= 1'b0;
      case (state)
        ST_HUNT: if (byte_take) begin
          if (start_evt) begin
            state     <= ST_DATA;
            cnt       <= '0;
            base      <= '0;
            crc       <= '0;
            have_pend <= 1'b0;
            end_seen  <= 1'b0;
            sof_seen  <= 1'b0;
          end else begin
            sof_seen <= (head == SOF_A);
          end
        end
        ST_DATA: begin
          if (end_evt) begin
            have_pend <= 1'b0;
            end_seen  <= 1'b1;
            idx       <= '0;
            state     <= (cnt != '0) ? ST_PGWR : ST_CRCH;
          end else if (byte_take) begin
            pend      <= head;
            have_pend <= 1'b1;
            if (store_evt) begin
              cnt <= cnt + 1'b1;
              crc <= crc16_step(crc, pend);
            end
            if (page_full) begin
              idx   <= '0;
              state <= ST_PGWR;
            end
          end
        end
        ST_PGWR: begin
          if (last_wr) state <= ST_PGCMT;
          else         idx   <= idx + 1'b1;
        end
        ST_PGCMT: state <= ST_PGWAIT;
        ST_PGWAIT: if (!ee_busy) begin
          base  <= base + ADDR_W'(cnt);
          cnt   <= '0;
          idx   <= '0;
          state <= end_seen ? ST_CRCH : ST_DATA;
        end
        ST_CRCH: if (byte_take) begin
          rcv_hi <= head;
          state  <= ST_CRCL;
        end
        ST_CRCL: if (byte_take) begin
          load_ok  <= crc_match;
          load_err <= !crc_match;
          sof_seen <= 1'b0;
          state    <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/fpl_checker.sv
module fpl_checker #(
  parameter int ADDR_W = 15,
  parameter int PAGE   = 64,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 7,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ee_we,
  input logic [ADDR_W-1:0] ee_addr,
  input logic              ee_commit,
  input logic              ee_busy,
  input logic              load_ok,
  input logic              load_err,
  input logic              byte_take,
  input logic              page_full,
  input logic              end_evt,
  input logic [CNT_W-1:0]  page_fill,
  input logic [LVL_W-1:0]  fifo_level
);
  logic [15:0] wr_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         wr_run <= '0;
    else if (ee_commit) wr_run <= '0;
    else if (ee_we)     wr_run <= wr_run + 1'b1;
  end

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_we && $past(ee_we)) |-> ee_addr == $past(ee_addr) + 1'b1);

  assert_full_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    page_full |=> ee_we);

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_commit |-> (wr_run >= 16'd1 && wr_run <= 16'(PAGE)));

  assert_commit_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_commit |=> !ee_commit);

  assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ee_busy |-> (!ee_we && !byte_take));

  assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  assert_partial_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && page_fill != '0) |=> ee_we);

  assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ok, load_err}));

  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok || load_err) |=> !(load_ok || load_err));
endmodule

bind fw_page_loader fpl_checker #(
  .ADDR_W (ADDR_W),
  .PAGE   (PAGE),
  .DEPTH  (FIFO_DEPTH),
  .CNT_W  (CNT_W),
  .LVL_W  (LVL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ee_we      (ee_we),
  .ee_addr    (ee_addr),
  .ee_commit  (ee_commit),
  .ee_busy    (ee_busy),
  .load_ok    (load_ok),
  .load_err   (load_err),
  .byte_take  (byte_take),
  .page_full  (page_full),
  .end_evt    (end_evt),
  .page_fill  (page_fill),
  .fifo_level (fifo_level)
);

// File: tb/fw_page_loader_test.sv
module fw_page_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 48;
  localparam int GAP        = 8;
  localparam int PG         = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        ee_we, ee_commit, ee_busy, load_ok, load_err;
  logic [14:0] ee_addr;
  logic [7:0]  ee_wdata;

  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_page_loader uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_commit(ee_commit), .ee_busy(ee_busy),
    .load_ok(load_ok), .load_err(load_err)
  );

  // EEPROM model: busy for BUSY_CYC cycles after a commit.
  int busy_left = 0;
  always @(posedge clk) begin
    if (!rst_n) busy_left <= 0;
    else if (ee_commit) busy_left <= BUSY_CYC;
    else if (busy_left > 0) busy_left <= busy_left - 1;
  end
  assign ee_busy = (busy_left > 0);

  // Port monitor, sampled away from the active edge.
  logic [7:0] mem [512];
  int c_addr [8];
  int c_len  [8];
  int n_commit = 0, cur_len = 0, cur_start = 0, we_total = 0;
  int ok_n = 0, err_n = 0, busy_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_we) begin
        mem[ee_addr[8:0]] = ee_wdata;
        if (cur_len == 0) cur_start = int'(ee_addr);
        cur_len++;
        we_total++;
        if (ee_busy) busy_viol++;
      end
      if (ee_commit) begin
        if (n_commit < 8) begin
          c_addr[n_commit] = cur_start;
          c_len[n_commit]  = cur_len;
        end
        n_commit++;
        cur_len = 0;
      end
      if (load_ok)  ok_n++;
      if (load_err) err_n++;
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  // Bit-serial CRC model: feedback = top bit xor incoming bit.
  function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[15] ^ b[k];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  logic [7:0] img [256];

  task automatic run_frame(input int len, input bit bad, input int seed, input string tag);
    logic [15:0] c = 16'h0000;
    int exp_pages, mism;
    n_commit = 0; cur_len = 0; ok_n = 0; err_n = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d = 8'((i * 37 + seed * 11 + 5) & 255);
      if (d == 8'hC3) d = 8'hC2;
      img[i] = d;
    end
    // R2: leading junk, including a doubled first marker byte.
    send(8'h11); send(8'hC3); send(8'h3C); send(8'hA5); send(8'hA5); send(8'h5A);
    for (int i = 0; i < len; i++) begin
      send(img[i]);
      c = crc_bits(c, img[i]);
    end
    send(8'hC3); send(8'h3C);
    send(c[15:8]);
    send(bad ? (c[7:0] ^ 8'h01) : c[7:0]);
    repeat (300) @(negedge clk);

    exp_pages = (len + PG - 1) / PG;
    chk(n_commit == exp_pages, {tag, " R4/R7 page count"}, n_commit, exp_pages);
    for (int p = 0; p < exp_pages && p < 8; p++) begin
      int el = (len - p * PG > PG) ? PG : len - p * PG;
      chk(c_len[p] == el, {tag, " R4/R7 page length"}, c_len[p], el);
      chk(c_addr[p] == p * PG, {tag, " R3 page start (R9 restart at 0)"}, c_addr[p], p * PG);
    end
    mism = 0;
    for (int i = 0; i < len; i++) if (mem[i] !== img[i]) mism++;
    chk(mism == 0, {tag, " R6/R3 image bytes in EEPROM"}, mism, 0);
    chk(ok_n == (bad ? 0 : 1), {tag, " R8 load_ok pulses"}, ok_n, bad ? 0 : 1);
    chk(err_n == (bad ? 1 : 0), {tag, " R8/R9 load_err pulses"}, err_n, bad ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ee_we, ee_commit, load_ok, load_err} == 4'b0, "R1 reset outputs",
        int'({ee_we, ee_commit, load_ok, load_err}), 0);

    // R2: junk with a broken start marker is ignored.
    send(8'h11); send(8'hC3); send(8'h3C); send(8'hA5); send(8'h77); send(8'h5A);
    repeat (100) @(negedge clk);
    chk(we_total == 0, "R2 no write while hunting", we_total, 0);
    chk(ok_n + err_n == 0, "R2 no result while hunting", ok_n + err_n, 0);

    run_frame(150, 1'b0, 1, "multi-page");
    run_frame(0,   1'b0, 2, "empty");
    run_frame(1,   1'b0, 3, "single byte");
    run_frame(64,  1'b0, 4, "exact page");
    run_frame(70,  1'b1, 5, "bad crc");
    run_frame(65,  1'b0, 6, "after error R9");
    run_frame(129, 1'b1, 7, "bad crc long");
    run_frame(127, 1'b0, 8, "rearm R9");

    chk(busy_viol == 0, "R5 no write while busy", busy_viol, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule